// File: doc/BRIEF.md
# EEPROM Write Buffer and Program Sequencer

This block sits behind the serial-bus front end of a small EEPROM and turns one write command into array writes. The front end signals that a write select byte was accepted, then passes on the address byte and each data byte. The block stores the data bytes in a small buffer. The write mode in force when the address arrives sets how many bytes the buffer holds. A STOP that ends the command starts a self-timed program cycle.

At the start of the program cycle the block writes the stored bytes to the array, one per clock. It then counts a programmable number of cycles. From the STOP until that count expires, the busy output is high and the front end is locked out.

In the standard build, a mode pin selects between two limits. When the pin is high, a short group of up to 4 bytes is allowed. When it is low, a full page of up to 8 bytes is allowed. A single byte works in either mode. In the write-control build the short-group path is removed, and a protect input can refuse every data byte.

Top module: `eeprom_wbuf`

## Requirements
- R1: After reset, `busy_o`, `mem_we_o` and `data_ack_o` are low.
- R2: `wr_begin_i` followed by `addr_valid_i` puts the block in its data phase. Each later `data_valid_i` pulse is answered in the same cycle with `data_ack_o` high, unless protection is active.
- R3: In the standard build, `mode_i` high when the address arrives selects a limit of 4 bytes. Address bits [1:0] advance from the start address and wrap inside the aligned 4-byte group, and the upper bits stay fixed.
- R4: `mode_i` low when the address arrives selects a limit of 8 bytes. Address bits [2:0] advance and wrap inside the aligned 8-byte page, and the upper bits stay fixed.
- R5: A command with a single data byte writes exactly that byte to the start address at either level of `mode_i`.
- R6: When more bytes arrive than the limit allows, byte j lands in slot j mod limit and overwrites the earlier byte there. The number of array writes is min(bytes, limit).
- R7: `stop_i` in the data phase, with at least one byte stored, starts the commit in the next cycle. During the commit, `mem_we_o` is high for one cycle per stored slot, in slot order starting from the start address.
- R8: `busy_o` rises in the cycle after that `stop_i` and stays high for (stored slots + `PROG_CYCLES`) cycles.
- R9: While `busy_o` is high, `data_ack_o` is low and `wr_begin_i`, `addr_valid_i`, `data_valid_i` and `stop_i` have no effect.
- R10: A `stop_i` with no stored byte, or outside a data phase, starts no write and no busy period.
- R11: In the write-control build (`WC_VARIANT`=1), `mode_i` is ignored and the limit is always 8.
- R12: In the write-control build, `wc_i` high blocks storage: data bytes get no acknowledge and no program cycle starts. In the standard build, `wc_i` is ignored.
- R13: A new `wr_begin_i` before `stop_i` discards every byte stored so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | Write mode: 1 selects the 4-byte group, 0 selects the 8-byte page |
| wc_i | input | 1 | Write protect, used only in the write-control build |
| wr_begin_i | input | 1 | Write select byte accepted |
| addr_valid_i | input | 1 | Address byte present on `addr_i` |
| addr_i | input | ADDR_W | Start address, including the block bit |
| data_valid_i | input | 1 | Data byte present on `data_i` |
| data_i | input | 8 | Data byte |
| stop_i | input | 1 | STOP seen on the bus |
| data_ack_o | output | 1 | Acknowledge for the current data byte |
| busy_o | output | 1 | Program cycle in progress |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_data_o | output | 8 | Array write data |

## Verification
The write path is swept over both mode levels, 1 to 10 data bytes, and start addresses at the bottom, middle and top of a group, page and block, with `wc_i` at both levels. Counts of 1 separate single-byte writes from group writes. Counts just above 4 and 8 show wrap overwrite as opposed to overflow. Start addresses near a page end show whether only the low bits wrap. A write-control instance runs alongside the standard one: the standard instance ignores `wc_i`, while the write-control instance ignores `mode_i` and stops when protected. Directed sequences inject commands during busy, issue STOPs with no data, and restart a command before its STOP.

// File: rtl/eeprom_wbuf.sv
module eeprom_wbuf #(
  parameter int ADDR_W      = 9,
  parameter int PAGE_BYTES  = 8,
  parameter int MULTI_BYTES = 4,
  parameter int WC_VARIANT  = 0,
  parameter int PROG_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              wc_i,
  input  logic              wr_begin_i,
  input  logic              addr_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_valid_i,
  input  logic [7:0]        data_i,
  input  logic              stop_i,
  output logic              data_ack_o,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o
);
  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int CNT_W  = $clog2(PAGE_BYTES + 1);
  localparam int PC_W   = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_COMMIT, S_WAIT} state_t;

  state_t            state_q;
  logic [ADDR_W-1:0] base_q;
  logic              multi_q;
  logic [SLOT_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0]  used_q;
  logic [PC_W-1:0]   pc_q;
  logic [7:0]        buf_q [PAGE_BYTES];

  logic              front_open, protect, take;
  logic [SLOT_W-1:0] lim_m1;
  logic [CNT_W-1:0]  lim;
  logic [ADDR_W-1:0] mask;

  assign front_open = (state_q == S_IDLE) || (state_q == S_ADDR) || (state_q == S_DATA);
  assign protect    = (WC_VARIANT != 0) && wc_i;
  assign take       = data_valid_i && (state_q == S_DATA) && !protect && !wr_begin_i && !stop_i;
  assign lim_m1     = multi_q ? SLOT_W'(MULTI_BYTES - 1) : SLOT_W'(PAGE_BYTES - 1);
  assign lim        = CNT_W'(lim_m1) + CNT_W'(1);
  assign mask       = ADDR_W'(lim_m1);

  assign data_ack_o = take;
  assign busy_o     = !front_open;
  assign mem_we_o   = (state_q == S_COMMIT);
  assign mem_addr_o = (base_q & ~mask) | ((base_q + ADDR_W'(rptr_q)) & mask);
  assign mem_data_o = buf_q[rptr_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      base_q  <= '0;
      multi_q <= 1'b0;
      wptr_q  <= '0;
      rptr_q  <= '0;
      used_q  <= '0;
      pc_q    <= '0;
    end else begin
      case (state_q)
        S_COMMIT: begin
          if (CNT_W'(rptr_q) + CNT_W'(1) == used_q) begin
            state_q <= S_WAIT;
            pc_q    <= PC_W'(PROG_CYCLES - 1);
          end else begin
            rptr_q <= rptr_q + SLOT_W'(1);
          end
        end
        S_WAIT: begin
          if (pc_q == '0) state_q <= S_IDLE;
          else            pc_q    <= pc_q - PC_W'(1);
        end
        default: begin
          if (wr_begin_i) begin
            state_q <= S_ADDR;
            used_q  <= '0;
            wptr_q  <= '0;
          end else if (stop_i) begin
            if (state_q == S_DATA && used_q != '0) begin
              state_q <= S_COMMIT;
              rptr_q  <= '0;
            end else begin
              state_q <= S_IDLE;
            end
          end else if (addr_valid_i && state_q == S_ADDR) begin
            base_q  <= addr_i;
            multi_q <= (WC_VARIANT == 0) && mode_i;
            state_q <= S_DATA;
          end else if (take) begin
            wptr_q <= (wptr_q == lim_m1) ? '0 : wptr_q + SLOT_W'(1);
            if (used_q != lim) used_q <= used_q + CNT_W'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take) buf_q[wptr_q] <= data_i;
  end
endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
  parameter int WC_VARIANT = 0
) (
  input logic clk,
  input logic rst_n,
  input logic stop_i,
  input logic wc_i,
  input logic data_ack_o,
  input logic busy_o,
  input logic mem_we_o
);
  // R9
  busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) busy_o |-> !data_ack_o);
  // R7
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we_o |-> busy_o);
  // R8
  busy_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_o) |-> $past(stop_i));
  // R8
  busy_tail_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_o) |-> !$past(mem_we_o));
  // R8
  wait_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_we_o) |-> busy_o);
  // R12
  protect_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) (WC_VARIANT != 0 && wc_i) |-> !data_ack_o);
endmodule

bind eeprom_wbuf wbuf_chk #(.WC_VARIANT(WC_VARIANT)) u_wbuf_chk (
  .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .wc_i(wc_i),
  .data_ack_o(data_ack_o), .busy_o(busy_o), .mem_we_o(mem_we_o)
);

// File: tb/tb_eeprom_wbuf.sv
module tb_eeprom_wbuf;
  localparam int PROG = 5;
  logic clk = 0, rst_n = 0;
  logic mode = 0, wc = 0, wr_begin = 0, addr_valid = 0, data_valid = 0, stop = 0;
  logic [8:0] addr = '0;
  logic [7:0] data = '0;
  logic ack0, busy0, we0, ack1, busy1, we1;
  logic [8:0] a0, a1;
  logic [7:0] d0, d1;

  always #10 clk = ~clk;

  eeprom_wbuf #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .wc_i(wc), .wr_begin_i(wr_begin),
    .addr_valid_i(addr_valid), .addr_i(addr), .data_valid_i(data_valid), .data_i(data),
    .stop_i(stop), .data_ack_o(ack0), .busy_o(busy0), .mem_we_o(we0),
    .mem_addr_o(a0), .mem_data_o(d0));

  eeprom_wbuf #(.PROG_CYCLES(PROG), .WC_VARIANT(1)) dut_wc (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .wc_i(wc), .wr_begin_i(wr_begin),
    .addr_valid_i(addr_valid), .addr_i(addr), .data_valid_i(data_valid), .data_i(data),
    .stop_i(stop), .data_ack_o(ack1), .busy_o(busy1), .mem_we_o(we1),
    .mem_addr_o(a1), .mem_data_o(d1));

  int checks = 0, errors = 0;
  int wn [2];
  int bc [2];
  logic [8:0] wa [2][16];
  logic [7:0] wd [2][16];

  always @(negedge clk) begin
    if (we0) begin if (wn[0] < 16) begin wa[0][wn[0]] = a0; wd[0][wn[0]] = d0; end wn[0]++; end
    if (we1) begin if (wn[1] < 16) begin wa[1][wn[1]] = a1; wd[1][wn[1]] = d1; end wn[1]++; end
    if (busy0) bc[0]++;
    if (busy1) bc[1]++;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] val(int base, int n, int j);
    return 8'(base * 7 + j * 13 + n * 3);
  endfunction

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic clear_log();
    for (int k = 0; k < 2; k++) begin wn[k] = 0; bc[k] = 0; end
  endtask

  task automatic begin_cmd(int base, bit md);
    step(); wr_begin = 1;
    step(); wr_begin = 0; addr_valid = 1; addr = 9'(base); mode = md;
    step(); addr_valid = 0; mode = ~md;
  endtask

  task automatic send_byte(logic [7:0] v, bit e0, bit e1, string req);
    data_valid = 1; data = v; #1;
    chk(ack0 == e0, req, ack0, e0);
    chk(ack1 == e1, req, ack1, e1);
    step(); data_valid = 0;
  endtask

  task automatic send_stop();
    stop = 1; step(); stop = 0;
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
    #1;
  endtask

  task automatic check_dut(int k, int lim, bit en, int base, int n, string tag);
    int cnt;
    cnt = en ? ((n < lim) ? n : lim) : 0;
    chk(wn[k] == cnt, "R6 write count", wn[k], cnt);
    chk(bc[k] == (en ? cnt + PROG : 0), "R8 busy length", bc[k], en ? cnt + PROG : 0);
    for (int i = 0; i < cnt && i < wn[k]; i++) begin
      int ea, j;
      ea = (base & ~(lim - 1)) | ((base + i) & (lim - 1));
      j  = i + lim * ((n - 1 - i) / lim);
      chk(wa[k][i] == 9'(ea), tag, wa[k][i], ea);
      chk(wd[k][i] == val(base, n, j), "R6 R7 slot data", wd[k][i], val(base, n, j));
    end
  endtask

  task automatic run_write(int base, int n, bit md, bit w);
    string tag;
    wc = w;
    clear_log();
    begin_cmd(base, md);
    for (int j = 0; j < n; j++) send_byte(val(base, n, j), 1'b1, !w, "R2 R12 data ack");
    send_stop();
    settle();
    if (n == 1) tag = "R5 single byte address";
    else if (md) tag = "R3 group wrap address";
    else tag = "R4 page wrap address";
    check_dut(0, md ? 4 : 8, 1'b1, base, n, tag);
    check_dut(1, 8, !w, base, n, (n == 1) ? "R5 R11 wc build address" : "R11 wc build address");
    wc = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bases [4] = '{0, 'h0F5, 'h1FE, 'h103};
    clear_log();
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    // R1
    chk(busy0 == 0 && busy1 == 0, "R1 busy after reset", busy0, 0);
    chk(we0 == 0 && we1 == 0, "R1 write strobe after reset", we0, 0);
    chk(ack0 == 0 && ack1 == 0, "R1 ack after reset", ack0, 0);

    for (int w = 0; w < 2; w++)
      for (int md = 0; md < 2; md++)
        for (int bi = 0; bi < 4; bi++)
          for (int n = 1; n <= 10; n++)
            run_write(bases[bi], n, md[0], w[0]);

    // R9 commands during busy are ignored; R10 stop outside a data phase
    clear_log();
    begin_cmd('h40, 1'b0);
    send_byte(8'h11, 1, 1, "R2 data ack");
    send_byte(8'h22, 1, 1, "R2 data ack");
    send_stop();
    wr_begin = 1; step(); wr_begin = 0;
    addr_valid = 1; addr = 9'h80; step(); addr_valid = 0;
    send_byte(8'h33, 0, 0, "R9 no ack while busy");
    send_stop();
    settle();
    chk(wn[0] == 2, "R9 writes during busy", wn[0], 2);
    chk(wa[0][1] == 9'h41 && wd[0][1] == 8'h22, "R9 second slot", wd[0][1], 8'h22);
    clear_log();
    send_byte(8'h44, 0, 0, "R9 no data phase after busy");
    send_stop();
    settle();
    chk(wn[0] == 0 && wn[1] == 0, "R9 R10 no write after ignored command", wn[0], 0);
    chk(bc[0] == 0 && bc[1] == 0, "R10 no busy after lone stop", bc[0], 0);

    // R10 address but no data
    clear_log();
    begin_cmd('h10, 1'b0);
    send_stop();
    settle();
    chk(wn[0] == 0 && bc[0] == 0, "R10 stop without data", bc[0], 0);

    // R13 restart discards earlier bytes
    clear_log();
    begin_cmd('h20, 1'b0);
    send_byte(8'hA1, 1, 1, "R2 data ack");
    send_byte(8'hA2, 1, 1, "R2 data ack");
    send_byte(8'hA3, 1, 1, "R2 data ack");
    begin_cmd('h35, 1'b1);
    send_byte(8'h5C, 1, 1, "R2 data ack");
    send_stop();
    settle();
    chk(wn[0] == 1, "R13 write count after restart", wn[0], 1);
    chk(wa[0][0] == 9'h35 && wd[0][0] == 8'h5C, "R13 surviving byte", wd[0][0], 8'h5C);
    chk(wn[1] == 1 && wa[1][0] == 9'h35, "R13 wc build restart", wn[1], 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule